// File: doc/BRIEF.md
# Debug Data-Bus Boundary Scan Register

This block is a 67-cell test data register for a JTAG-style debug port. It sits on a processor's data bus. The cells hold 32 data bits, 32 instruction bits and three control bits. A test access port controller drives the block with single-cycle capture, shift and update strobes, and serial data passes from `tdi_i` to `tdo_o`.

The register has three uses, selected by a mode input:

- **Internal test:** it samples the core's data, instruction and drive-enable values.
- **External test:** it either drives the data-bus pins from the scanned data cells or samples those pins. A scanned drive-enable cell selects which.
- **Debug:** it feeds an instruction and a speed-resynchronisation choice to the core. On the first capture after debug entry, it also reports whether a breakpoint or a watchpoint caused that entry.

Shifting never disturbs the parallel outputs. Only an update strobe moves the shifted contents into the holding registers that drive the pins and the core.

Top module: `dbus_scan_chain`

## Requirements
- R1: After synchronous reset, the shift cells, holding registers, cause-pending flag, `tdo_o`, `pin_oe_o`, `inj_instr_o` and `sys_speed_o` are all 0.
- R2: The chain is 67 bits long. Bit k of a scanned vector has data[31:0] at k=0..31, instruction[31:0] at k=32..63, the breakpoint-after-watchpoint cell at k=64, the speed cell at k=65 and the drive-enable cell at k=66. On each shift strobe, `tdo_o` presents cell k=0 first and `tdi_i` enters at k=66. After 67 shifts, the first bit fed in sits at k=0.
- R3: Shift and capture strobes leave the holding registers, `inj_instr_o`, `sys_speed_o`, `pin_data_o` and `pin_oe_o` unchanged.
- R4: An update strobe copies all 67 shift cells into the holding registers. On the next cycle, `inj_instr_o` shows the instruction field and `sys_speed_o` shows the speed cell.
- R5: In internal test mode (`mode_i`=01), capture loads `core_data_i` into the data cells and `core_dden_i` into the drive-enable cell. In debug mode (`mode_i`=00 or 11), capture loads `core_data_i` and the drive-enable cell keeps its value. In every mode, capture loads `core_instr_i` into the instruction cells.
- R6: In external test mode (`mode_i`=10), if the held drive-enable bit is 1, `pin_oe_o` is 1, `pin_data_o` equals the held data field, and capture leaves the data cells unchanged.
- R7: In external test mode, if the held drive-enable bit is 0, `pin_oe_o` is 0 and capture loads `pin_data_i` into the data cells.
- R8: A `dbg_entry_i` pulse records `dbg_cause_i` (0 = breakpoint, 1 = watchpoint). The next capture loads that cause into the speed cell.
- R9: Once a capture has reported the cause, later captures leave the speed cell holding the last value scanned into it, until the next debug entry.
- R10: Every capture loads `wpt_bkpt_i` into the breakpoint-after-watchpoint cell.
- R11: Outside external test mode, `pin_oe_o` is 0 whatever the held drive-enable bit is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | 00 debug, 01 internal test, 10 external test, 11 treated as debug |
| capture_i | input | 1 | Capture-DR strobe |
| shift_i | input | 1 | Shift-DR strobe |
| update_i | input | 1 | Update-DR strobe |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out (cell 0) |
| core_data_i | input | 32 | Core data value for internal test and debug capture |
| core_instr_i | input | 32 | Core instruction value for capture |
| core_dden_i | input | 1 | Core drive-enable value for internal test capture |
| pin_data_i | input | 32 | Value present on the data-bus pins |
| pin_data_o | output | 32 | Value to drive on the data-bus pins |
| pin_oe_o | output | 1 | Data-bus pin output enable |
| dbg_entry_i | input | 1 | Pulse when the core enters debug state |
| dbg_cause_i | input | 1 | Entry cause: 0 breakpoint, 1 watchpoint |
| wpt_bkpt_i | input | 1 | Instruction after a watchpointed one also had a breakpoint |
| inj_instr_o | output | 32 | Held instruction for the core to execute |
| sys_speed_o | output | 1 | Held choice to resynchronise to system speed |

## Verification
A table of scan rounds exercises the capture in each mode:

- internal test, with distinct core data, instruction and drive-enable values;
- external test, entered first with a driving held state and then with a sampling one, so that retained data cells and captured pin values are told apart;
- debug mode with a drive-enable of 1, which shows that the pins stay released.

A loop-back scan with no capture proves the bit order end to end. Debug-entry sequences with both cause values, followed by second captures, separate the one-shot cause report from the retained speed value.

// File: rtl/dbscan_pkg.sv
package dbscan_pkg;
    localparam int DATA_W    = 32;
    localparam int INSTR_W   = 32;
    localparam int CTRL_W    = 3;
    localparam int CHAIN_W   = DATA_W + INSTR_W + CTRL_W;
    localparam int WPBK_POS  = DATA_W + INSTR_W;
    localparam int SPEED_POS = WPBK_POS + 1;
    localparam int DDEN_POS  = WPBK_POS + 2;

    typedef enum logic [1:0] {
        MODE_DEBUG  = 2'b00,
        MODE_INTEST = 2'b01,
        MODE_EXTEST = 2'b10,
        MODE_RSVD   = 2'b11
    } scan_mode_e;

    // Packed so the MSB is the TDI end and the LSB is the TDO end.
    typedef struct packed {
        logic               dden;
        logic               speed;
        logic               wpbk;
        logic [INSTR_W-1:0] instr;
        logic [DATA_W-1:0]  data;
    } chain_t;

    function automatic logic drives_pins(scan_mode_e m, logic held_dden);
        return (m == MODE_EXTEST) && held_dden;
    endfunction
endpackage

// File: rtl/dbs_cause_tracker.sv
module dbs_cause_tracker (
    input  logic clk,
    input  logic rst,
    input  logic entry_i,
    input  logic cause_i,
    input  logic capture_i,
    output logic pending_o,
    output logic cause_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pending_o <= 1'b0;
            cause_o   <= 1'b0;
        end else begin
            if (entry_i) begin
                pending_o <= 1'b1;
                cause_o   <= cause_i;
            end else if (capture_i) begin
                pending_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dbs_shift_reg.sv
module dbs_shift_reg #(
    parameter int W = 67
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         capture_i,
    input  logic         shift_i,
    input  logic         tdi_i,
    input  logic [W-1:0] cap_vec_i,
    output logic [W-1:0] sr_o,
    output logic         tdo_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sr_o <= '0;
        end else if (capture_i) begin
            sr_o <= cap_vec_i;
        end else if (shift_i) begin
            sr_o <= {tdi_i, sr_o[W-1:1]};
        end
    end

    assign tdo_o = sr_o[0];
endmodule

// File: rtl/dbs_update_stage.sv
module dbs_update_stage #(
    parameter int W = 67
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         update_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_o <= '0;
        end else if (update_i) begin
            q_o <= d_i;
        end
    end
endmodule

// File: rtl/dbus_scan_chain.sv
module dbus_scan_chain
    import dbscan_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          mode_i,
    input  logic                capture_i,
    input  logic                shift_i,
    input  logic                update_i,
    input  logic                tdi_i,
    output logic                tdo_o,
    input  logic [DATA_W-1:0]   core_data_i,
    input  logic [INSTR_W-1:0]  core_instr_i,
    input  logic                core_dden_i,
    input  logic [DATA_W-1:0]   pin_data_i,
    output logic [DATA_W-1:0]   pin_data_o,
    output logic                pin_oe_o,
    input  logic                dbg_entry_i,
    input  logic                dbg_cause_i,
    input  logic                wpt_bkpt_i,
    output logic [INSTR_W-1:0]  inj_instr_o,
    output logic                sys_speed_o
);
    logic [CHAIN_W-1:0] sr_q;
    logic [CHAIN_W-1:0] hold_q;
    logic [CHAIN_W-1:0] cap_vec;
    logic               cause_pending;
    logic               cause_val;
    scan_mode_e         mode;
    chain_t             cur;
    chain_t             held;
    chain_t             cap;

    assign mode = scan_mode_e'(mode_i);
    assign cur  = chain_t'(sr_q);
    assign held = chain_t'(hold_q);

    dbs_cause_tracker u_cause (
        .clk       (clk),
        .rst       (rst),
        .entry_i   (dbg_entry_i),
        .cause_i   (dbg_cause_i),
        .capture_i (capture_i),
        .pending_o (cause_pending),
        .cause_o   (cause_val)
    );

    // Capture vector: each cell takes its source for the current mode; cells
    // without a source keep their shifted value.
    always_comb begin
        cap       = cur;
        cap.instr = core_instr_i;
        cap.wpbk  = wpt_bkpt_i;
        if (cause_pending) begin
            cap.speed = cause_val;
        end
        unique case (mode)
            MODE_INTEST: begin
                cap.dden = core_dden_i;
                cap.data = core_data_i;
            end
            MODE_EXTEST: begin
                if (!held.dden) begin
                    cap.data = pin_data_i;
                end
            end
            default: begin
                cap.data = core_data_i;
            end
        endcase
    end

    assign cap_vec = cap;

    dbs_shift_reg #(.W(CHAIN_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .capture_i (capture_i),
        .shift_i   (shift_i),
        .tdi_i     (tdi_i),
        .cap_vec_i (cap_vec),
        .sr_o      (sr_q),
        .tdo_o     (tdo_o)
    );

    dbs_update_stage #(.W(CHAIN_W)) u_update (
        .clk      (clk),
        .rst      (rst),
        .update_i (update_i),
        .d_i      (sr_q),
        .q_o      (hold_q)
    );

    assign pin_data_o  = held.data;
    assign pin_oe_o    = drives_pins(mode, held.dden);
    assign inj_instr_o = held.instr;
    assign sys_speed_o = held.speed;
endmodule

// File: rtl/dbs_checker.sv
module dbs_checker
    import dbscan_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [1:0]         mode_i,
    input logic               capture_i,
    input logic               shift_i,
    input logic               update_i,
    input logic               tdo_o,
    input logic               pin_oe_o,
    input logic               dbg_entry_i,
    input logic               wpt_bkpt_i,
    input logic [CHAIN_W-1:0] sr_q,
    input logic [CHAIN_W-1:0] hold_q,
    input logic               cause_pending,
    input logic               cause_val
);
    AST_TDO_FOLLOWS_CHAIN: assert property (@(posedge clk) disable iff (rst)
        (shift_i && !capture_i) |=> (tdo_o == $past(sr_q[1]))); // R2

    AST_HOLD_ONLY_ON_UPDATE: assert property (@(posedge clk) disable iff (rst)
        !update_i |=> $stable(hold_q)); // R3

    AST_UPDATE_COPIES_CHAIN: assert property (@(posedge clk) disable iff (rst)
        update_i |=> (hold_q == $past(sr_q))); // R4

    AST_CAUSE_ON_FIRST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (capture_i && cause_pending) |=> (sr_q[SPEED_POS] == $past(cause_val))); // R8

    AST_PENDING_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (capture_i && !dbg_entry_i) |=> !cause_pending); // R9

    AST_WPBK_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        capture_i |=> (sr_q[WPBK_POS] == $past(wpt_bkpt_i))); // R10

    AST_OE_EXTEST_ONLY: assert property (@(posedge clk) disable iff (rst)
        pin_oe_o |-> (mode_i == MODE_EXTEST)); // R11
endmodule

bind dbus_scan_chain dbs_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .mode_i        (mode_i),
    .capture_i     (capture_i),
    .shift_i       (shift_i),
    .update_i      (update_i),
    .tdo_o         (tdo_o),
    .pin_oe_o      (pin_oe_o),
    .dbg_entry_i   (dbg_entry_i),
    .wpt_bkpt_i    (wpt_bkpt_i),
    .sr_q          (sr_q),
    .hold_q        (hold_q),
    .cause_pending (cause_pending),
    .cause_val     (cause_val)
);

// File: tb/tb_dbus_scan_chain.sv
module tb_dbus_scan_chain;
    localparam int CLK_PERIOD = 10;
    localparam int NBITS      = 67;
    localparam int NROWS      = 5;
    localparam int WD_LIMIT   = 20000;

    typedef struct packed {
        logic [1:0]       mode;
        logic [31:0]      cdata;
        logic [31:0]      cinstr;
        logic             cdden;
        logic             wpbk;
        logic [31:0]      pin;
        logic [NBITS-1:0] vec;
    } row_t;

    // vec = {dden, speed, wpbk, instr[31:0], data[31:0]}
    localparam row_t ROWS [NROWS] = '{
        '{2'b01, 32'hA5A5_0F0F, 32'h1234_5678, 1'b1, 1'b1, 32'h0000_0000,
          {1'b1, 1'b1, 1'b0, 32'hDEAD_BEEF, 32'h0BAD_F00D}},
        '{2'b10, 32'h1111_1111, 32'h8765_4321, 1'b0, 1'b0, 32'h3C3C_3C3C,
          {1'b1, 1'b0, 1'b1, 32'h0000_FFFF, 32'hCAFE_F00D}},
        '{2'b10, 32'h2222_2222, 32'hFFFF_0000, 1'b1, 1'b1, 32'h5A5A_5A5A,
          {1'b0, 1'b1, 1'b0, 32'h1357_9BDF, 32'h2468_ACE0}},
        '{2'b10, 32'h3333_3333, 32'h0F0F_0F0F, 1'b0, 1'b0, 32'h9696_6969,
          {1'b0, 1'b0, 1'b1, 32'hAAAA_5555, 32'h7777_8888}},
        '{2'b00, 32'h4444_4444, 32'hF0F0_F0F0, 1'b1, 1'b1, 32'hFFFF_FFFF,
          {1'b1, 1'b0, 1'b0, 32'h0102_0304, 32'h0506_0708}}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  mode_i;
    logic        capture_i, shift_i, update_i, tdi_i;
    logic        tdo_o;
    logic [31:0] core_data_i, core_instr_i, pin_data_i, pin_data_o, inj_instr_o;
    logic        core_dden_i, pin_oe_o, dbg_entry_i, dbg_cause_i, wpt_bkpt_i, sys_speed_o;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    logic [NBITS-1:0] prev_vec;
    logic [NBITS-1:0] held_vec;
    logic [NBITS-1:0] got;
    logic [NBITS-1:0] expv;
    logic             pend;
    logic             pend_cause;
    row_t             rw;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbus_scan_chain dut (
        .clk(clk), .rst(rst), .mode_i(mode_i), .capture_i(capture_i),
        .shift_i(shift_i), .update_i(update_i), .tdi_i(tdi_i), .tdo_o(tdo_o),
        .core_data_i(core_data_i), .core_instr_i(core_instr_i),
        .core_dden_i(core_dden_i), .pin_data_i(pin_data_i),
        .pin_data_o(pin_data_o), .pin_oe_o(pin_oe_o),
        .dbg_entry_i(dbg_entry_i), .dbg_cause_i(dbg_cause_i),
        .wpt_bkpt_i(wpt_bkpt_i), .inj_instr_o(inj_instr_o),
        .sys_speed_o(sys_speed_o)
    );

    task automatic check(input string req, input logic [NBITS-1:0] act,
                         input logic [NBITS-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse_capture();
        capture_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        capture_i = 1'b0;
        if (!dbg_entry_i) pend = 1'b0;
    endtask

    task automatic pulse_update();
        update_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        update_i = 1'b0;
    endtask

    task automatic pulse_entry(input logic cause);
        dbg_entry_i = 1'b1;
        dbg_cause_i = cause;
        @(posedge clk);
        @(negedge clk);
        dbg_entry_i = 1'b0;
        pend        = 1'b1;
        pend_cause  = cause;
    endtask

    task automatic scan(input logic [NBITS-1:0] v, output logic [NBITS-1:0] o);
        for (int i = 0; i < NBITS; i++) begin
            o[i]    = tdo_o;
            tdi_i   = v[i];
            shift_i = 1'b1;
            @(posedge clk);
            @(negedge clk);
        end
        shift_i = 1'b0;
        tdi_i   = 1'b0;
    endtask

    // Expected capture result from the requirements.
    function automatic logic [NBITS-1:0] model_capture(input logic [1:0] m);
        logic [NBITS-1:0] e = prev_vec;
        e[63:32] = core_instr_i;
        e[64]    = wpt_bkpt_i;
        if (pend) e[65] = pend_cause;
        if (m == 2'b01) begin
            e[66]   = core_dden_i;
            e[31:0] = core_data_i;
        end else if (m == 2'b10) begin
            if (!held_vec[66]) e[31:0] = pin_data_i;
        end else begin
            e[31:0] = core_data_i;
        end
        return e;
    endfunction

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WD_LIMIT) begin
                bad++;
                total++;
                $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, WD_LIMIT);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        rst = 1'b1; mode_i = 2'b00; capture_i = 1'b0; shift_i = 1'b0;
        update_i = 1'b0; tdi_i = 1'b0; core_data_i = '0; core_instr_i = '0;
        core_dden_i = 1'b0; pin_data_i = '0; dbg_entry_i = 1'b0;
        dbg_cause_i = 1'b0; wpt_bkpt_i = 1'b0;
        pend = 1'b0; pend_cause = 1'b0; prev_vec = '0; held_vec = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state at the ports
        check("R1 tdo", NBITS'(tdo_o), '0);
        check("R1 pin_oe", NBITS'(pin_oe_o), '0);
        check("R1 inj_instr", NBITS'(inj_instr_o), '0);
        check("R1 sys_speed", NBITS'(sys_speed_o), '0);

        // R2: loop-back, no capture; the shifted-out image must equal the input
        scan({1'b1, 1'b0, 1'b1, 32'h8000_0001, 32'hC001_D00D}, got);
        check("R2 reset chain empty", got, '0);
        scan('0, got);
        check("R2 bit order", got, {1'b1, 1'b0, 1'b1, 32'h8000_0001, 32'hC001_D00D});
        check("R3 no update during shift", NBITS'(inj_instr_o), '0);
        prev_vec = '0;

        // Table of scan rounds
        for (int r = 0; r < NROWS; r++) begin
            rw = ROWS[r];
            mode_i = rw.mode; core_data_i = rw.cdata; core_instr_i = rw.cinstr;
            core_dden_i = rw.cdden; wpt_bkpt_i = rw.wpbk; pin_data_i = rw.pin;
            expv = model_capture(rw.mode);
            pulse_capture();
            scan(rw.vec, got);
            check("R5/R6/R7/R9/R10 captured chain", got, expv);
            check("R3 held instr stable", NBITS'(inj_instr_o), NBITS'(held_vec[63:32]));
            check("R3 held speed stable", NBITS'(sys_speed_o), NBITS'(held_vec[65]));
            pulse_update();
            held_vec = rw.vec;
            prev_vec = rw.vec;
            check("R4 inj_instr", NBITS'(inj_instr_o), NBITS'(rw.vec[63:32]));
            check("R4 sys_speed", NBITS'(sys_speed_o), NBITS'(rw.vec[65]));
            check("R6/R11 pin_oe", NBITS'(pin_oe_o),
                  NBITS'((rw.mode == 2'b10) && rw.vec[66]));
            if (pin_oe_o) check("R6 pin_data", NBITS'(pin_data_o), NBITS'(rw.vec[31:0]));
        end

        // R8/R9: watchpoint entry while the speed cell holds 0
        mode_i = 2'b00;
        pulse_entry(1'b1);
        pulse_capture();
        scan({1'b0, 1'b0, 1'b0, 32'h0, 32'h0}, got);
        check("R8 watchpoint cause", NBITS'(got[65]), NBITS'(1'b1));
        pulse_capture();
        scan({1'b0, 1'b1, 1'b0, 32'h0, 32'h0}, got);
        check("R9 retained speed 0", NBITS'(got[65]), NBITS'(1'b0));

        // R8/R9: breakpoint entry while the speed cell holds 1
        pulse_entry(1'b0);
        pulse_capture();
        scan({1'b0, 1'b1, 1'b0, 32'h0, 32'h0}, got);
        check("R8 breakpoint cause", NBITS'(got[65]), NBITS'(1'b0));
        pulse_capture();
        scan('0, got);
        check("R9 retained speed 1", NBITS'(got[65]), NBITS'(1'b1));

        // R11: debug mode with a held drive-enable of 1 leaves the pins released
        scan({1'b1, 1'b0, 1'b0, 32'h0, 32'hFFFF_0000}, got);
        pulse_update();
        mode_i = 2'b11;
        @(negedge clk);
        check("R11 mode 11 pins released", NBITS'(pin_oe_o), '0);
        mode_i = 2'b10;
        @(negedge clk);
        check("R6 extest drives", NBITS'(pin_oe_o), NBITS'(1'b1));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule